// File: doc/BRIEF.md
# Programmable Beep Tone Generator

The block produces a square-wave tone, one signed 24-bit sample per audio sample tick, for mixing into a playback stream. Four register fields set the tone: a 4-bit pitch code, a 4-bit burst-length code, a 3-bit gap-length code and a 5-bit level code. A 2-bit mode field chooses between silence, a single burst, repeated bursts separated by silent gaps, and a tone that runs with no time limit.

All timing is counted in sample ticks (`tick_i`). The tone half-period is a whole or half number of ticks, and a phase accumulator spreads the half-tick remainder. When the mode field is cleared in the middle of a burst, the tone runs on to the end of its current half-period. This avoids a click. `busy_o` is high for as long as a burst or a gap is in progress.

Top module: `beep_gen`

## Requirements
- R1: After `rst_ni` is asserted low, `busy_o` is 0 and `sample_o` is 0.
- R2: With `mode_i` = 00 the block is idle: `busy_o` stays 0 and `sample_o` stays 0 whatever ticks arrive.
- R3: The half-period, in units of half-ticks, is hp2 = floor(46/(f+1)) for pitch code f. An accumulator starts at 0 when a burst starts and adds 2 on every tick in a burst. When the sum reaches hp2 or more, the phase flips and hp2 is subtracted from the sum. Code 0000 flips every 23 ticks. Code 0001 flips after 12 ticks, then 11, then 12, and so on.
- R4: During a burst, `sample_o` is +A while the phase is high and -A while it is low. The phase is high for the first half-period after each burst start. Outside a burst (idle or gap) `sample_o` is 0.
- R5: For level code g, the index s = (6 - g) mod 32 gives a level of +6 - 2*s dB. Code 00110 is +6 dB, 00000 is -6 dB, 11111 is -8 dB and 00111 is -56 dB.
- R6: Write s = 3q + r with r in 0..2. Then A = min(2^23-1, (2*REF_LEVEL*M[r]) >> (16+q)), with M = {65536, 52057, 41350} and REF_LEVEL defaulting to 2^22. So code 6 gives 8388607 (saturated), code 3 gives 4194304, code 31 gives 1665824 and code 7 gives 6507. `sample_o` is never -2^23.
- R7: Mode 01 starts exactly one burst on a tick while idle. When that burst ends, the block stays idle until it sees `mode_i` = 00 on a tick.
- R8: A burst lasts ON_BASE*(1+4k) ticks after its starting tick, where k is the burst-length code. The default ON_BASE is 1032, so code 0000 gives 1032 ticks.
- R9: Mode 10 alternates bursts with silent gaps. A gap lasts OFF_BASE*(j+1) ticks, where j is the gap-length code, with a default OFF_BASE of 516. `busy_o` stays 1 through the gap.
- R10: Mode 11 plays a tone with no time limit. `busy_o` stays 1 for as long as `mode_i` is 11.
- R11: Setting `mode_i` to 00 during a burst ends it on the tick where the phase would next flip. Setting it to 00 during a gap ends the gap on the next tick.
- R12: Internal state changes only on cycles with `tick_i` = 1. `busy_o` and the sign of `sample_o` hold steady between ticks.
- R13: `busy_o` is 1 exactly while a burst or a gap is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per audio sample |
| mode_i | input | 2 | 00 off, 01 single, 10 repeat, 11 continuous |
| freq_i | input | 4 | Pitch code |
| on_code_i | input | 4 | Burst length code |
| off_code_i | input | 3 | Gap length code |
| gain_i | input | 5 | Level code |
| busy_o | output | 1 | Burst or gap in progress |
| sample_o | output | 24 | Signed tone sample |

## Verification
The bench measures the half-period lengths in ticks. A fixed-point pitch divider would give 12/12 or 11/11 instead of alternating 12 and 11 for code 0001, and an off-by-one in the accumulator would show up as 22 or 24 for code 0000. It times single bursts and repeat gaps to the exact tick, which catches counters that end one tick early or late, and it confirms that a single burst does not restart while the mode is held. It clears the mode in mid-burst and in mid-gap: a design that cut the tone at once would click, and one that waited for the end of the burst would overrun. It also probes the wrapped level codes and the saturated top code.

// File: rtl/beep_pkg.sv
package beep_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_OFF} beep_state_e;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_ONE   = 2'b01;
  localparam logic [1:0] MODE_MULTI = 2'b10;
  localparam logic [1:0] MODE_CONT  = 2'b11;

  // magnitude for a level code: +6 dB at code 6, 2 dB per step, wraps mod 32
  function automatic logic [SAMPLE_W-2:0] amp_of(input int code, input longint ref_lvl);
    int s, q, r;
    longint m, v, lim;
    s = (6 - code) & 31;
    q = s / 3;
    r = s % 3;
    m = (r == 0) ? 65536 : ((r == 1) ? 52057 : 41350);
    v = (2 * ref_lvl * m) >>> (16 + q);
    lim = (longint'(1) <<< (SAMPLE_W - 1)) - 1;
    if (v > lim) v = lim;
    return v[SAMPLE_W-2:0];
  endfunction
endpackage

// File: rtl/beep_tone.sv
module beep_tone #(
  parameter int FREQ_W   = 4,
  parameter int HP2_BASE = 46
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              adv_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              edge_o,
  output logic              ph_o
);
  localparam int NCODE = 1 << FREQ_W;
  localparam int ACC_W = $clog2(2 * HP2_BASE + 3);

  logic [ACC_W-1:0] hp2_lut [NCODE];
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  for (genvar g = 0; g < NCODE; g++) begin : g_hp2
    assign hp2_lut[g] = ACC_W'(HP2_BASE / (g + 1));
  end

  assign acc_sum = acc_q + ACC_W'(2);
  assign edge_o  = acc_sum >= hp2_lut[freq_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ph_o  <= 1'b1;
    end else if (restart_i) begin
      acc_q <= '0;
      ph_o  <= 1'b1;
    end else if (adv_i) begin
      if (edge_o) begin
        acc_q <= acc_sum - hp2_lut[freq_i];
        ph_o  <= ~ph_o;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/beep_seq.sv
module beep_seq
  import beep_pkg::*;
#(
  parameter int ON_W    = 4,
  parameter int OFF_W   = 3,
  parameter int ON_BASE  = 1032,
  parameter int OFF_BASE = 516
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [ON_W-1:0]  on_code_i,
  input  logic [OFF_W-1:0] off_code_i,
  input  logic             tone_edge_i,
  output beep_state_e      state_o,
  output logic             tone_adv_o,
  output logic             tone_restart_o
);
  localparam int N_ON    = 1 << ON_W;
  localparam int N_OFF   = 1 << OFF_W;
  localparam int ON_MAX  = ON_BASE * (1 + 4 * (N_ON - 1));
  localparam int OFF_MAX = OFF_BASE * N_OFF;
  localparam int LIM_MAX = (ON_MAX > OFF_MAX) ? ON_MAX : OFF_MAX;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] on_lim  [N_ON];
  logic [CNT_W-1:0] off_lim [N_OFF];

  for (genvar g = 0; g < N_ON; g++) begin : g_on
    assign on_lim[g] = CNT_W'(ON_BASE * (1 + 4 * g));
  end
  for (genvar g = 0; g < N_OFF; g++) begin : g_off
    assign off_lim[g] = CNT_W'(OFF_BASE * (g + 1));
  end

  beep_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             restart;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    restart = 1'b0;
    if (tick_i) begin
      if (mode_i == MODE_OFF) done_d = 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (mode_i[1] || (mode_i == MODE_ONE && !done_q)) begin
            state_d = ST_ON;
            cnt_d   = '0;
            restart = 1'b1;
          end
        end
        ST_ON: begin
          if (mode_i == MODE_OFF) begin
            if (tone_edge_i) state_d = ST_IDLE;  // finish on a half-period boundary
          end else if (mode_i != MODE_CONT) begin
            if (cnt_q == on_lim[on_code_i] - CNT_W'(1)) begin
              cnt_d = '0;
              if (mode_i == MODE_MULTI) begin
                state_d = ST_OFF;
              end else begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_OFF: begin
          if (mode_i == MODE_OFF) begin
            state_d = ST_IDLE;
          end else if (cnt_q == off_lim[off_code_i] - CNT_W'(1)) begin
            state_d = ST_ON;
            cnt_d   = '0;
            restart = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign state_o        = state_q;
  assign tone_adv_o     = tick_i && (state_q == ST_ON);
  assign tone_restart_o = restart;
endmodule

// File: rtl/beep_level.sv
module beep_level
  import beep_pkg::*;
#(
  parameter int     GAIN_W    = 5,
  parameter longint REF_LEVEL = 64'd4194304
) (
  input  logic [GAIN_W-1:0]   gain_i,
  output logic [SAMPLE_W-2:0] amp_o
);
  localparam int NCODE = 1 << GAIN_W;

  logic [SAMPLE_W-2:0] amp_lut [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_amp
    assign amp_lut[g] = amp_of(g, REF_LEVEL);
  end

  assign amp_o = amp_lut[gain_i];
endmodule

// File: rtl/beep_gen.sv
module beep_gen
  import beep_pkg::*;
#(
  parameter int     ON_BASE   = 1032,
  parameter int     OFF_BASE  = 516,
  parameter int     HP2_BASE  = 46,
  parameter longint REF_LEVEL = 64'd4194304
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [1:0]                 mode_i,
  input  logic [3:0]                 freq_i,
  input  logic [3:0]                 on_code_i,
  input  logic [2:0]                 off_code_i,
  input  logic [4:0]                 gain_i,
  output logic                       busy_o,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  beep_state_e         state;
  logic                tone_adv, tone_restart, tone_edge, ph;
  logic [SAMPLE_W-2:0] amp;
  logic signed [SAMPLE_W-1:0] mag;

  beep_seq #(
    .ON_W(4), .OFF_W(3), .ON_BASE(ON_BASE), .OFF_BASE(OFF_BASE)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_i),
    .on_code_i(on_code_i), .off_code_i(off_code_i), .tone_edge_i(tone_edge),
    .state_o(state), .tone_adv_o(tone_adv), .tone_restart_o(tone_restart)
  );

  beep_tone #(.FREQ_W(4), .HP2_BASE(HP2_BASE)) u_tone (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(tone_restart), .adv_i(tone_adv),
    .freq_i(freq_i), .edge_o(tone_edge), .ph_o(ph)
  );

  beep_level #(.GAIN_W(5), .REF_LEVEL(REF_LEVEL)) u_level (
    .gain_i(gain_i), .amp_o(amp)
  );

  assign mag      = {1'b0, amp};
  assign busy_o   = state != ST_IDLE;
  assign sample_o = (state == ST_ON) ? (ph ? mag : -mag) : '0;
endmodule

// File: rtl/beep_gen_chk.sv
module beep_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic [1:0]  mode_i,
  input logic        busy_o,
  input logic [23:0] sample_o
);
  // R4
  silent_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sample_o == 24'd0);

  // R6
  no_neg_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != 24'h800000);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(busy_o));

  // R12
  sign_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sample_o[23]));

  // R10
  cont_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_i == 2'b11) |=> busy_o);

  // R7
  single_no_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && mode_i == 2'b01 && $past(mode_i) == 2'b01)
      |=> (!busy_o || mode_i != 2'b01));
endmodule

bind beep_gen beep_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_i),
  .busy_o(busy_o), .sample_o(sample_o)
);

// File: tb/sim_beep_gen.sv
`timescale 1ns/1ps
module sim_beep_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  freq_i = 4'd0;
  logic [3:0]  on_code_i = 4'd0;
  logic [2:0]  off_code_i = 3'd0;
  logic [4:0]  gain_i = 5'd3;
  logic        busy_o;
  logic signed [23:0] sample_o;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;

  always #2.5 clk_i = ~clk_i;

  beep_gen u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ref_amp(input int g);
    int s, q, r;
    longint m, v;
    s = (6 - g) & 31; q = s / 3; r = s % 3;
    m = (r == 0) ? 65536 : ((r == 1) ? 52057 : 41350);
    v = (2 * 64'd4194304 * m) >>> (16 + q);
    return (v > 8388607) ? 8388607 : v;
  endfunction

  // behavioural reference: 0 idle, 1 burst, 2 gap
  int m_st, m_acc, m_cnt;
  bit m_ph, m_done;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_acc = 0; m_cnt = 0; m_ph = 1; m_done = 0;
    end else if (tick_i) begin
      int hp2, onl, offl;
      bit flip;
      hp2  = 46 / (int'(freq_i) + 1);
      onl  = 1032 * (1 + 4 * int'(on_code_i));
      offl = 516 * (int'(off_code_i) + 1);
      flip = (m_acc + 2) >= hp2;
      if (mode_i == 0) m_done = 0;
      if (m_st == 0) begin
        if (mode_i >= 2 || (mode_i == 1 && !m_done)) begin
          m_st = 1; m_cnt = 0; m_acc = 0; m_ph = 1;
        end
      end else if (m_st == 1) begin
        if (mode_i == 0) begin
          if (flip) m_st = 0;
        end else if (mode_i != 3 && m_cnt == onl - 1) begin
          m_cnt = 0;
          if (mode_i == 2) m_st = 2; else begin m_st = 0; m_done = 1; end
        end else if (mode_i != 3) m_cnt++;
        if (m_st == 1) begin
          if (flip) begin m_acc = m_acc + 2 - hp2; m_ph = ~m_ph; end
          else m_acc = m_acc + 2;
        end
      end else begin
        if (mode_i == 0) m_st = 0;
        else if (m_cnt == offl - 1) begin
          m_st = 1; m_cnt = 0; m_acc = 0; m_ph = 1;
        end else m_cnt++;
      end
    end
  end

  // every-cycle comparison, R13 busy and R4 sample
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done_run) begin
      longint es;
      es = (m_st == 1) ? (m_ph ? ref_amp(gain_i) : -ref_amp(gain_i)) : 0;
      chk("R13 busy", busy_o, m_st != 0);
      chk("R4 sample", sample_o, es);
    end
  end

  task automatic tk(input int n = 1, input int gap = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      for (int k = 0; k < gap; k++) @(negedge clk_i) tick_i = 1'b0;
    end
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  // ticks until the sign of sample_o flips
  task automatic half_len(output int len);
    bit s0;
    s0 = sample_o[23];
    len = 0;
    do begin tk(1); len++; end while (sample_o[23] == s0 && len < 200);
  endtask

  // ticks until busy_o drops
  task automatic busy_len(output int len);
    len = 0;
    do begin tk(1); len++; end while (busy_o && len < 30000);
  endtask

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 sample", sample_o, 0);
    rst_ni = 1'b1;

    // R2: idle mode ignores ticks
    tk(50);
    chk("R2 busy", busy_o, 0);
    chk("R2 sample", sample_o, 0);

    // R3 code 0, continuous
    freq_i = 4'd0; gain_i = 5'd3; mode_i = 2'b11;
    tk(1);
    chk("R4 first half positive", sample_o, 4194304);
    half_len(len); chk("R3 code0 half1", len, 23);
    half_len(len); chk("R3 code0 half2", len, 23);
    // R5/R6 level codes
    gain_i = 5'd6;  @(negedge clk_i); chk("R6 code6 sat", sample_o > 0 ? sample_o : -sample_o, 8388607);
    gain_i = 5'd0;  @(negedge clk_i); chk("R5 code0 -6dB", sample_o > 0 ? sample_o : -sample_o, 2097152);
    gain_i = 5'd31; @(negedge clk_i); chk("R5 code31 -8dB", sample_o > 0 ? sample_o : -sample_o, 1665824);
    gain_i = 5'd7;  @(negedge clk_i); chk("R5 code7 -56dB", sample_o > 0 ? sample_o : -sample_o, 6507);
    gain_i = 5'd5;  @(negedge clk_i); chk("R6 code5", sample_o > 0 ? sample_o : -sample_o, 6663296);
    // R10: long continuous run stays busy
    tk(3000);
    chk("R10 still busy", busy_o, 1);
    // R11: stop lands on the boundary
    half_len(len);
    mode_i = 2'b00;
    busy_len(len); chk("R11 stop at boundary", len, 23);

    // R3 code 1 alternation
    freq_i = 4'd1; mode_i = 2'b11; tk(1);
    half_len(len); chk("R3 code1 first", len, 12);
    half_len(len); chk("R3 code1 second", len, 11);
    half_len(len); chk("R3 code1 third", len, 12);
    mode_i = 2'b00; tk(30);
    chk("R11 stopped", busy_o, 0);

    // R7/R8 single burst
    freq_i = 4'd4; on_code_i = 4'd0; mode_i = 2'b01;
    tk(1); chk("R7 started", busy_o, 1);
    busy_len(len); chk("R8 code0 length", len, 1032);
    tk(200); chk("R7 no retrigger", busy_o, 0);
    mode_i = 2'b00; tk(1); mode_i = 2'b01;
    on_code_i = 4'd1;
    tk(1); chk("R7 rearmed", busy_o, 1);
    busy_len(len); chk("R8 code1 length", len, 5160);

    // R9 repeat with gaps
    mode_i = 2'b00; tk(1);
    on_code_i = 4'd0; off_code_i = 3'd0; freq_i = 4'd2; mode_i = 2'b10;
    tk(1);
    len = 0;
    do begin tk(1); len++; end while (sample_o != 0 && len < 3000);
    chk("R9 burst length", len, 1032);
    chk("R9 busy in gap", busy_o, 1);
    len = 0;
    do begin tk(1); len++; end while (sample_o == 0 && len < 3000);
    chk("R9 gap length", len, 516);
    chk("R4 restart positive", sample_o > 0, 1);
    off_code_i = 3'd2;
    tk(1100);
    chk("R9 in long gap", sample_o, 0);
    mode_i = 2'b00; tk(1);
    chk("R11 gap ends at once", busy_o, 0);

    // R12: sparse ticks, pitch change mid-tone
    freq_i = 4'd15; mode_i = 2'b11;
    tk(40, 2);
    freq_i = 4'd0;
    tk(60, 3);
    freq_i = 4'd9;
    tk(40, 1);
    chk("R12 busy", busy_o, 1);
    mode_i = 2'b00;
    tk(60, 1);
    chk("R12 stopped", busy_o, 0);

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule